// File: doc/BRIEF.md
# Reset and Power-Fail Supervisor

This block watches the health of a small system's supplies and turns it into three active-low reset-style outputs and one interrupt. A power-on reset (`por_n`) is held low while the main rail is not good. Once the main rail has been good for a programmable number of timer ticks, the power-on reset is released. The tick count is chosen by a strap between a short and a long value. A processor reset (`cpu_rst_n`) follows the power-on reset. A qualified hot-reset event adds a fixed-width pulse to it.

A power-fail warning (`pfail_n`) drops on any of these conditions: a low-battery flag, an over-temperature warning, removal of the battery cover, or an active power-on reset. When the debounced cover signal falls, a pending flag is set. That flag drives `cover_irq` unless software masks it, and software clears the flag with a strobe.

All delays are counted in `tick` pulses. A system uses a 1 ms tick, and a simulation can use a fast tick with small parameter values.

Top module: `reset_supervisor`

## Requirements
- R1: `por_n` is low in every cycle in which `main_pg` is low, including the same cycle it falls.
- R2: With `main_pg` held high, `por_n` goes high in the cycle after the clock edge that samples the N-th `tick` seen with `main_pg` high, where N is the selected delay.
- R3: N equals `POR_TICKS_SHORT` (default 100, i.e. 100 ms at a 1 ms tick) when `long_delay` is 0, and `POR_TICKS_LONG` (default 1000, i.e. 1 s) when `long_delay` is 1.
- R4: A `hot_evt` sampled while `core_pg` and `por_n` are high drives `cpu_rst_n` low from the next cycle. It stays low until `CPU_RST_TICKS` further ticks have been sampled, and a tick in the loading cycle does not count. A `hot_evt` sampled with `core_pg` low has no effect on `cpu_rst_n`.
- R5: `cpu_rst_n` is low in every cycle in which `por_n` is low.
- R6: `pfail_n` is low exactly when any of these holds: `low_batt` is high, `over_temp` is high, `cover_ok` is low, or `por_n` is low.
- R7: A 1-to-0 transition of `cover_ok` sets a pending flag on that edge, and `cover_irq` is the pending flag gated by `!irq_mask`. Masking hides the flag but does not clear it. `irq_clr` clears the flag unless a new fall is sampled in the same cycle.
- R8: If `main_pg` drops while the power-on delay is being counted, the count restarts from zero, and the full N ticks are needed after `main_pg` returns.
- R9: A qualified `hot_evt` during an active processor-reset pulse reloads the pulse. `cpu_rst_n` then stays low for a full `CPU_RST_TICKS` ticks from the new event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block's state |
| tick | input | 1 | One-cycle timebase pulse (1 ms in a system) |
| main_pg | input | 1 | Main rail power-good |
| core_pg | input | 1 | Core rail in regulation |
| hot_evt | input | 1 | Debounced hot-reset request, one-cycle pulse |
| cover_ok | input | 1 | Debounced battery-cover present (1 = in place) |
| low_batt | input | 1 | Battery voltage below warning level |
| over_temp | input | 1 | Imminent over-temperature shutdown |
| long_delay | input | 1 | Strap: 0 selects the short power-on delay, 1 the long one |
| irq_mask | input | 1 | Masks `cover_irq` when high |
| irq_clr | input | 1 | Clears the pending cover interrupt |
| por_n | output | 1 | Active-low power-on reset |
| cpu_rst_n | output | 1 | Active-low processor reset |
| pfail_n | output | 1 | Active-low power-fail warning |
| cover_irq | output | 1 | Cover-removal interrupt |

## Verification
Every cycle, the assertions check the combinational holds: power-on reset with the main rail down, processor reset and power-fail under the power-on reset, and power-fail under each warning input. They also check that a power-on release only follows a tick, that a qualified hot event pulls the processor reset down on the next cycle, and that a cover fall is latched. The tick counts cannot be seen by a one-cycle property. These are the exact delay under each strap setting, the restart of the delay after a power-good glitch, the pulse width, and its reload by a second event. The bench scenarios show them by comparing every cycle against a behavioural model and by measuring the tick counts directly. The same applies to the ignored hot event and to a masked interrupt that reappears on unmasking.

// File: rtl/reset_supervisor.sv
module reset_supervisor #(
  parameter int unsigned POR_TICKS_SHORT = 100,
  parameter int unsigned POR_TICKS_LONG  = 1000,
  parameter int unsigned CPU_RST_TICKS   = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic main_pg,
  input  logic core_pg,
  input  logic hot_evt,
  input  logic cover_ok,
  input  logic low_batt,
  input  logic over_temp,
  input  logic long_delay,
  input  logic irq_mask,
  input  logic irq_clr,
  output logic por_n,
  output logic cpu_rst_n,
  output logic pfail_n,
  output logic cover_irq
);
  localparam int unsigned MAXP = (POR_TICKS_LONG > POR_TICKS_SHORT) ? POR_TICKS_LONG : POR_TICKS_SHORT;
  localparam int unsigned CW = $clog2(MAXP + 1);
  localparam int unsigned PW = $clog2(CPU_RST_TICKS + 1);

  logic [CW-1:0] por_cnt;
  logic          por_done;
  logic [PW-1:0] pulse_cnt;
  logic          cover_q;
  logic          irq_pend;

  wire [CW-1:0] por_lim  = long_delay ? CW'(POR_TICKS_LONG) : CW'(POR_TICKS_SHORT);
  wire          cover_fall = cover_q & ~cover_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      por_cnt  <= '0;
      por_done <= 1'b0;
    end else if (!main_pg) begin
      por_cnt  <= '0;
      por_done <= 1'b0;
    end else if (!por_done && tick) begin
      if (por_cnt == por_lim - CW'(1)) begin
        por_cnt  <= '0;
        por_done <= 1'b1;
      end else begin
        por_cnt <= por_cnt + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      pulse_cnt <= '0;
    else if (!por_n)                 pulse_cnt <= '0;
    else if (hot_evt && core_pg)     pulse_cnt <= PW'(CPU_RST_TICKS);
    else if (tick && pulse_cnt != 0) pulse_cnt <= pulse_cnt - PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cover_q  <= 1'b1;
      irq_pend <= 1'b0;
    end else begin
      cover_q <= cover_ok;
      if (cover_fall)   irq_pend <= 1'b1;
      else if (irq_clr) irq_pend <= 1'b0;
    end
  end

  assign por_n     = por_done & main_pg;
  assign cpu_rst_n = por_n & (pulse_cnt == 0);
  assign pfail_n   = por_n & cover_ok & ~low_batt & ~over_temp;
  assign cover_irq = irq_pend & ~irq_mask;
endmodule

module reset_supervisor_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic main_pg,
  input logic core_pg,
  input logic hot_evt,
  input logic cover_ok,
  input logic low_batt,
  input logic over_temp,
  input logic irq_mask,
  input logic por_n,
  input logic cpu_rst_n,
  input logic pfail_n,
  input logic cover_irq
);
  // R1
  por_low_no_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !main_pg |-> !por_n);
  // R2
  por_release_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(por_n) |-> ($past(tick) && $past(main_pg)));
  // R4
  hot_pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hot_evt && core_pg && por_n) |=> !cpu_rst_n);
  // R5
  cpu_under_por_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !por_n |-> !cpu_rst_n);
  // R6
  pfail_under_por_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !por_n |-> !pfail_n);
  // R6
  pfail_warn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (low_batt || over_temp || !cover_ok) |-> !pfail_n);
  // R7
  cover_fall_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cover_ok) |=> (cover_irq || irq_mask));
  // R7
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mask |-> !cover_irq);
endmodule

bind reset_supervisor reset_supervisor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .main_pg(main_pg), .core_pg(core_pg),
  .hot_evt(hot_evt), .cover_ok(cover_ok), .low_batt(low_batt), .over_temp(over_temp),
  .irq_mask(irq_mask), .por_n(por_n), .cpu_rst_n(cpu_rst_n), .pfail_n(pfail_n),
  .cover_irq(cover_irq)
);

// File: tb/reset_supervisor_tb.sv
module reset_supervisor_tb;
  localparam int SHORT = 5;
  localparam int LONG  = 12;
  localparam int PULSE = 4;

  logic clk = 0, rst_n = 0, tick = 0;
  logic main_pg = 0, core_pg = 0, hot_evt = 0, cover_ok = 1;
  logic low_batt = 0, over_temp = 0, long_delay = 0, irq_mask = 0, irq_clr = 0;
  logic por_n, cpu_rst_n, pfail_n, cover_irq;

  int n_chk = 0, n_fail = 0;
  int ticks_seen = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  reset_supervisor #(.POR_TICKS_SHORT(SHORT), .POR_TICKS_LONG(LONG), .CPU_RST_TICKS(PULSE)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .main_pg(main_pg), .core_pg(core_pg),
    .hot_evt(hot_evt), .cover_ok(cover_ok), .low_batt(low_batt), .over_temp(over_temp),
    .long_delay(long_delay), .irq_mask(irq_mask), .irq_clr(irq_clr),
    .por_n(por_n), .cpu_rst_n(cpu_rst_n), .pfail_n(pfail_n), .cover_irq(cover_irq));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // timebase: one tick every third cycle, driven away from the edge
  initial begin
    int d = 0;
    forever begin
      @(posedge clk); #2;
      d = (d + 1) % 3;
      tick = (d == 0);
    end
  end

  // behavioural reference
  int  m_cnt = 0, m_pulse = 0;
  bit  m_done = 0, m_prev = 1, m_pend = 0;
  always @(posedge clk) begin
    bit por;
    if (tick) ticks_seen++;
    if (!rst_n) begin
      m_cnt = 0; m_done = 0; m_pulse = 0; m_prev = 1; m_pend = 0;
    end else begin
      por = m_done && main_pg;
      if (!main_pg) begin m_done = 0; m_cnt = 0; end
      else if (!m_done && tick) begin
        m_cnt++;
        if (m_cnt == (long_delay ? LONG : SHORT)) begin m_done = 1; m_cnt = 0; end
      end
      if (!por) m_pulse = 0;
      else if (hot_evt && core_pg) m_pulse = PULSE;
      else if (tick && m_pulse > 0) m_pulse--;
      if (m_prev && !cover_ok) m_pend = 1;
      else if (irq_clr) m_pend = 0;
      m_prev = cover_ok;
    end
  end

  always @(negedge clk) begin
    bit e_por;
    if (rst_n && !finished) begin
      e_por = m_done && main_pg;
      chk(por_n === e_por, "R1/R2 por_n", por_n, e_por);
      chk(cpu_rst_n === (e_por && m_pulse == 0), "R4/R5 cpu_rst_n", cpu_rst_n, e_por && m_pulse == 0);
      chk(pfail_n === (e_por && cover_ok && !low_batt && !over_temp), "R6 pfail_n",
          pfail_n, e_por && cover_ok && !low_batt && !over_temp);
      chk(cover_irq === (m_pend && !irq_mask), "R7 cover_irq", cover_irq, m_pend && !irq_mask);
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
  endtask

  task automatic measure_por(output int n);
    int t0 = ticks_seen;
    int guard = 0;
    do begin @(negedge clk); guard++; end while (!por_n && guard < 500);
    n = ticks_seen - t0;
  endtask

  task automatic hot_and_measure(output int n);
    int t0;
    int guard = 0;
    hot_evt = 1; step(); hot_evt = 0;
    @(negedge clk); t0 = ticks_seen;
    while (!cpu_rst_n && guard < 500) begin @(negedge clk); guard++; end
    n = ticks_seen - t0;
  endtask

  initial begin
    int n;
    int t0;
    bit stayed;
    step(3);
    rst_n = 1;
    @(negedge clk);
    chk(!por_n && !cpu_rst_n && !pfail_n && !cover_irq, "R1 R5 R6 reset state",
        {por_n, cpu_rst_n, pfail_n, cover_irq}, 0);

    // R3 short delay
    step(); main_pg = 1; core_pg = 1;
    measure_por(n);
    chk(n == SHORT, "R3 short delay ticks", n, SHORT);
    step(2);
    chk(pfail_n && cpu_rst_n, "R6 pfail_n/cpu high when healthy", {pfail_n, cpu_rst_n}, 3);

    // R6 individual warnings
    low_batt = 1; @(negedge clk);
    chk(!pfail_n, "R6 low_batt", pfail_n, 0);
    step(); low_batt = 0; over_temp = 1; @(negedge clk);
    chk(!pfail_n, "R6 over_temp", pfail_n, 0);
    step(); over_temp = 0; @(negedge clk);
    chk(pfail_n, "R6 recovered", pfail_n, 1);

    // R4 ignored without core regulation
    step(); core_pg = 0; hot_evt = 1; step(); hot_evt = 0;
    stayed = 1;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (!cpu_rst_n) stayed = 0; end
    chk(stayed, "R4 hot_evt ignored with core_pg low", stayed, 1);
    step(); core_pg = 1;

    // R4 pulse width
    hot_and_measure(n);
    chk(n == PULSE, "R4 pulse width ticks", n, PULSE);

    // R9 restart during pulse
    step(3);
    hot_evt = 1; step(); hot_evt = 0;
    t0 = ticks_seen;
    while (ticks_seen < t0 + 2) @(negedge clk);
    chk(!cpu_rst_n, "R9 pulse active before retrigger", cpu_rst_n, 0);
    step();
    hot_and_measure(n);
    chk(n == PULSE, "R9 full width after retrigger", n, PULSE);

    // R7 cover interrupt
    step(); cover_ok = 0; step(); @(negedge clk);
    chk(cover_irq && !pfail_n, "R7 irq on cover fall", {cover_irq, pfail_n}, 2);
    step(); irq_clr = 1; step(); irq_clr = 0; @(negedge clk);
    chk(!cover_irq, "R7 cleared", cover_irq, 0);
    irq_mask = 1; cover_ok = 1; step(); cover_ok = 0; step(2); @(negedge clk);
    chk(!cover_irq, "R7 masked", cover_irq, 0);
    step(); irq_mask = 0; @(negedge clk);
    chk(cover_irq, "R7 pending after unmask", cover_irq, 1);
    step(); irq_clr = 1; step(); irq_clr = 0; cover_ok = 1;

    // R1 R5 drop main rail, R8 restart with long delay
    step(); main_pg = 0; #1;
    chk(!por_n && !cpu_rst_n, "R1 R5 main rail drop", {por_n, cpu_rst_n}, 0);
    step(); long_delay = 1; main_pg = 1;
    t0 = ticks_seen;
    while (ticks_seen < t0 + 3) @(negedge clk);
    step(); main_pg = 0; step(); main_pg = 1;
    measure_por(n);
    chk(n == LONG, "R8 R3 restart, long delay ticks", n, LONG);

    step(5);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog act=0 exp=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule